// File: doc/BRIEF.md
# Serial Port Data Register with Write-Collision Detect

This block is the data path behind the single 16-bit data register of a serial peripheral port, seen from a processor's register bus. A register write goes straight into the transmit shift register, which has no staging stage in front of it. A register read returns a separate receive holding buffer. That buffer is refilled only when a character has fully arrived, so software can read the previous character while the next one is still shifting.

Characters are 8 or 16 bits long, chosen by a mode input. Bits leave from the character's top bit and arrive at bit 0, so data always moves toward the MSB. Byte-lane enables allow byte-wide or word-wide writes. A write attempted while a transfer is in progress is discarded and latches a sticky collision flag. A transfer-complete flag reports each refill of the holding buffer. Clock generation, slave select, clock polarity and phase, and interrupts belong to the surrounding port. This block only consumes a per-bit shift enable and a start pulse.

Top module: `spi_xfer_buf`

## Requirements
- R1: After reset, busy, the collision flag, the complete flag, rd_data and ser_out are all 0.
- R2: A write while idle loads the shift register directly: each byte lane i whose wr_be[i] is 1 takes wr_data[8i+7:8i], and lanes whose enable is 0 keep their contents.
- R3: A start pulse raises busy at the next clock only if at least one idle write has been accepted since the last accepted start. A start with no such write leaves busy low.
- R4: busy falls at the clock of the 8th shift enable (wide_mode=0) or the 16th shift enable (wide_mode=1) counted from the start. A shift enable while idle changes nothing.
- R5: ser_out shows bit 7 (wide_mode=0) or bit 15 (wide_mode=1) of the shift register. Each shift moves the register one place toward the MSB and enters ser_in at bit 0, so the first bit received ends up as the character's top bit.
- R6: A write while busy leaves the shift register unchanged and sets the collision flag.
- R7: The collision flag stays set until a clock with wcol_clr=1 clears it. When a blocked write and wcol_clr occur in the same clock, the flag stays set.
- R8: In 8-bit mode a completed character is returned in rd_data[7:0] with rd_data[15:8]=0, and a write to the upper byte lane (wr_be[1]) is ignored.
- R9: rd_data changes only at the clock on which a transfer completes. During a later transfer it keeps the previously received character.
- R10: The complete flag is set at the clock that loads the holding buffer and is cleared by rd_en. When a load and rd_en occur in the same clock, the flag stays set.
- R11: A low-lane-only write in 16-bit mode keeps the upper byte of the shift register, which is then transmitted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 16-bit characters, 0 = 8-bit characters |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe; clears the complete flag |
| rd_data | output | 16 | Receive holding buffer |
| start | input | 1 | Transfer start pulse |
| shift_en | input | 1 | One-cycle enable per serial bit |
| ser_in | input | 1 | Incoming serial bit |
| ser_out | output | 1 | Outgoing serial bit (character MSB) |
| busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears the collision flag |
| done_flag | output | 1 | Transfer-complete flag |

## Verification
Transfers are run in both character lengths, with the transmitted word and the incoming serial pattern chosen independently. This separates the outgoing bit order from the incoming bit order, and shows whether the upper byte is masked in 8-bit mode. Single-bit, all-ones, all-zero and alternating words expose off-by-one errors in the bit count and swapped ends. Loopback transfers, where the received word must equal the written word, reveal any write that slips in while busy, a byte lane that is wrongly written, or an upper-lane write that should have been dropped. Cycles where a flag's set and clear coincide decide the priority of the collision and complete flags.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int WORD_W  = 16;
    localparam int SHORT_W = 8;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef enum logic {
        LEN8  = 1'b0,
        LEN16 = 1'b1
    } char_len_e;

    typedef struct packed {
        logic              en;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [CNT_W-1:0] last_index(char_len_e len);
        return (len == LEN16) ? CNT_W'(WORD_W - 1) : CNT_W'(SHORT_W - 1);
    endfunction

    function automatic logic [WORD_W-1:0] fmt_rx(logic [WORD_W-1:0] d, char_len_e len);
        return (len == LEN16) ? d : {{(WORD_W-SHORT_W){1'b0}}, d[SHORT_W-1:0]};
    endfunction

    function automatic logic lane_allowed(int lane, char_len_e len);
        return (len == LEN16) || (lane < SHORT_W / BYTE_W);
    endfunction

endpackage

// File: rtl/spi_xfer_shift.sv
module spi_xfer_shift
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  char_len_e         len,
    input  logic              start,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              busy,
    output logic              wr_blocked,
    output logic              load,
    output logic [WORD_W-1:0] load_data
);

    logic [WORD_W-1:0] sreg, sreg_d;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    logic              step;
    logic              last;
    logic [LANES-1:0]  lane_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = wr.en && !busy && wr.be[g] && lane_allowed(g, len);
    end

    assign step = busy && shift_en;
    assign last = step && (cnt == last_index(len));

    always_comb begin
        sreg_d = sreg;
        if (step) begin
            sreg_d = {sreg[WORD_W-2:0], ser_in};
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_wr[i]) sreg_d[i*BYTE_W +: BYTE_W] = wr.data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            cnt   <= '0;
            armed <= 1'b0;
            busy  <= 1'b0;
        end else begin
            sreg <= sreg_d;
            if (wr.en && !busy) armed <= 1'b1;
            if (start && armed && !busy) begin
                busy  <= 1'b1;
                armed <= 1'b0;
                cnt   <= '0;
            end else if (step) begin
                cnt <= cnt + 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    assign ser_out    = (len == LEN16) ? sreg[WORD_W-1] : sreg[SHORT_W-1];
    assign wr_blocked = wr.en && busy;
    assign load       = last;
    assign load_data  = fmt_rx(sreg_d, len);

endmodule

// File: rtl/spi_xfer_rxhold.sv
module spi_xfer_rxhold
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              done_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            done_flag <= 1'b0;
        end else begin
            if (load) rd_data <= load_data;
            if (load)       done_flag <= 1'b1;
            else if (rd_en) done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_xfer_wcol.sv
module spi_xfer_wcol (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/spi_xfer_buf.sv
module spi_xfer_buf
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              start,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              busy,
    output logic              wcol,
    input  logic              wcol_clr,
    output logic              done_flag
);

    wr_req_t           wr;
    char_len_e         len;
    logic              wr_blocked;
    logic              load;
    logic [WORD_W-1:0] load_data;

    assign wr  = '{en: wr_en, be: wr_be, data: wr_data};
    assign len = wide_mode ? LEN16 : LEN8;

    spi_xfer_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .len        (len),
        .start      (start),
        .shift_en   (shift_en),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .busy       (busy),
        .wr_blocked (wr_blocked),
        .load       (load),
        .load_data  (load_data)
    );

    spi_xfer_rxhold u_rxhold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .done_flag (done_flag)
    );

    spi_xfer_wcol u_wcol (
        .clk  (clk),
        .rst  (rst),
        .set  (wr_blocked),
        .clr  (wcol_clr),
        .flag (wcol)
    );

endmodule

// File: rtl/spi_xfer_buf_chk.sv
module spi_xfer_buf_chk
    import spi_xfer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wide_mode,
    input logic              wr_en,
    input logic              start,
    input logic              shift_en,
    input logic              busy,
    input logic              wcol,
    input logic              wcol_clr,
    input logic              done_flag,
    input logic [WORD_W-1:0] rd_data
);

    logic [CNT_W-1:0] seen;
    logic             wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= '0;
            wide_q <= 1'b0;
        end else if (!busy) begin
            seen   <= '0;
            wide_q <= wide_mode;
        end else if (shift_en) begin
            seen <= seen + 1'b1;
        end
    end

    // R4: a transfer ends after exactly one character's worth of shifts
    p_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (seen == (wide_q ? CNT_W'(WORD_W) : CNT_W'(SHORT_W))));

    // R3: busy only rises on a start
    p_start_only_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    // R6: a write during a transfer raises the collision flag
    p_collide_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> wcol);

    // R7: flag holds until cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (wcol && !wcol_clr) |=> wcol);

    // R8: upper byte reads zero after an 8-bit character
    p_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !wide_q) |-> (rd_data[WORD_W-1:SHORT_W] == '0));

    // R9: holding buffer changes only on completion
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(rd_data));

    // R10: completion raises the complete flag
    p_done_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_flag);

endmodule

bind spi_xfer_buf spi_xfer_buf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .wr_en     (wr_en),
    .start     (start),
    .shift_en  (shift_en),
    .busy      (busy),
    .wcol      (wcol),
    .wcol_clr  (wcol_clr),
    .done_flag (done_flag),
    .rd_data   (rd_data)
);

// File: tb/spi_xfer_buf_bench.sv
module spi_xfer_buf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // fields: [48] wide, [47:32] written word, [31:16] incoming pattern, [15:0] expected rd_data
    localparam logic [48:0] VECS [NVEC] = '{
        {1'b1, 16'hA5C3, 16'h3C5A, 16'h3C5A},
        {1'b1, 16'h0001, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h1280, 16'h00B7, 16'h00B7},
        {1'b0, 16'hFF7F, 16'hAB4E, 16'h004E},
        {1'b1, 16'h8000, 16'h8001, 16'h8001},
        {1'b0, 16'h0000, 16'h00FF, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        start = 1'b0;
    logic        shift_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        busy;
    logic        wcol;
    logic        wcol_clr = 1'b0;
    logic        done_flag;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_xfer_buf u_spi_xfer_buf (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .start     (start),
        .shift_en  (shift_en),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .busy      (busy),
        .wcol      (wcol),
        .wcol_clr  (wcol_clr),
        .done_flag (done_flag)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write_word(input logic [1:0] be, input logic [15:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_xfer(input bit loop, input logic [15:0] pat, input int col_at,
                           input logic [15:0] col_data, input bit rd_last,
                           output logic [15:0] outbits, output logic [15:0] mid_rd,
                           output bit busy_ok);
        int n;
        n = wide_mode ? 16 : 8;
        outbits = '0;
        mid_rd  = '0;
        busy_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (busy !== 1'b1) busy_ok = 1'b0;
            if (i == n/2) mid_rd = rd_data;
            outbits[n-1-i] = ser_out;
            ser_in = loop ? ser_out : pat[n-1-i];
            if (i == col_at) begin
                wr_en = 1'b1; wr_be = 2'b11; wr_data = col_data;
            end
            rd_en = rd_last && (i == n-1);
            shift_en = 1'b1;
            @(negedge clk);
            shift_en = 1'b0; wr_en = 1'b0; wr_be = 2'b00; rd_en = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] ob, mid, prev;
        bit bok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 wcol", {15'd0, wcol}, 16'd0);
        check("R1 done", {15'd0, done_flag}, 16'd0);
        check("R1 rd_data", rd_data, 16'd0);
        check("R1 ser_out", {15'd0, ser_out}, 16'd0);

        // R3: start with no preceding write is ignored
        pulse_start();
        check("R3 start without write", {15'd0, busy}, 16'd0);

        // table walk: R2 R5 R4 R8 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [48:0] v;
            v = VECS[k];
            wide_mode = v[48];
            write_word(2'b11, v[47:32]);
            pulse_start();
            check("R3 busy after start", {15'd0, busy}, 16'd1);
            do_xfer(1'b0, v[31:16], -1, 16'h0, 1'b0, ob, mid, bok);
            check("R4 busy held for character", {15'd0, bok}, 16'd1);
            check("R5 bits out MSB first", ob, v[48] ? v[47:32] : {8'h00, v[39:32]});
            check("R4 busy low after last shift", {15'd0, busy}, 16'd0);
            check("R10 done set on load", {15'd0, done_flag}, 16'd1);
            check("R2 R8 received word", rd_data, v[15:0]);
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
            check("R10 done cleared by read", {15'd0, done_flag}, 16'd0);
        end

        // R3: start after a completed transfer with no new write
        pulse_start();
        check("R3 start needs fresh write", {15'd0, busy}, 16'd0);

        // R4: shift enables while idle do nothing
        wide_mode = 1'b1;
        write_word(2'b11, 16'h8000);
        ser_in = 1'b0;
        shift_en = 1'b1; repeat (3) @(negedge clk); shift_en = 1'b0;
        check("R4 idle shift ignored", {15'd0, ser_out}, 16'd1);
        check("R4 idle stays idle", {15'd0, busy}, 16'd0);

        // R6: write during transfer is discarded and flagged (loopback)
        write_word(2'b11, 16'hC3A5);
        pulse_start();
        do_xfer(1'b1, 16'h0, 5, 16'h0F0F, 1'b0, ob, mid, bok);
        check("R6 collision flag", {15'd0, wcol}, 16'd1);
        check("R6 shift register untouched", rd_data, 16'hC3A5);

        // R7: sticky, clear, set wins
        @(negedge clk);
        check("R7 flag sticky", {15'd0, wcol}, 16'd1);
        wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
        check("R7 cleared", {15'd0, wcol}, 16'd0);
        write_word(2'b11, 16'h5A3C);
        pulse_start();
        wr_en = 1'b1; wr_be = 2'b11; wr_data = 16'hFFFF; wcol_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wcol_clr = 1'b0;
        check("R7 set wins over clear", {15'd0, wcol}, 16'd1);
        wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
        check("R7 clear alone", {15'd0, wcol}, 16'd0);
        prev = rd_data;
        do_xfer(1'b1, 16'h0, -1, 16'h0, 1'b1, ob, mid, bok);
        check("R9 old word held mid transfer", mid, prev);
        check("R6 R9 new word after completion", rd_data, 16'h5A3C);
        check("R10 load wins over read", {15'd0, done_flag}, 16'd1);

        // R11: low-lane write keeps upper byte
        write_word(2'b11, 16'h1234);
        write_word(2'b01, 16'h00CD);
        pulse_start();
        do_xfer(1'b1, 16'h0, -1, 16'h0, 1'b0, ob, mid, bok);
        check("R11 partial write", rd_data, 16'h12CD);

        // R8: upper-lane write ignored in 8-bit mode
        write_word(2'b11, 16'h1234);
        wide_mode = 1'b0;
        write_word(2'b10, 16'hAB00);
        wide_mode = 1'b1;
        pulse_start();
        do_xfer(1'b1, 16'h0, -1, 16'h0, 1'b0, ob, mid, bok);
        check("R8 upper lane write ignored", rd_data, 16'h1234);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule